// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the interrupt conditions of a serial port into one active-high interrupt line and one identification byte that software reads to learn which condition needs service. Five conditions compete: receiver line errors, a received character waiting, a receive-FIFO character timeout, an empty transmit holding register and a modem input change. A four-bit enable mask decides which of them may raise the interrupt. When several are active, the byte names the most urgent one.

The receive, line-error, timeout and modem conditions are level inputs from their own logic. The transmit-empty condition is different: it is latched here by a small state machine with two states. `TXE_IDLE` means no transmit-empty interrupt is owed. `TXE_PEND` means one is owed. The machine moves `TXE_IDLE -> TXE_PEND` on an arm event. An arm event is either a rising edge of the empty flag, or the transmit enable going from 0 to 1 while the register is empty. It moves `TXE_PEND -> TXE_IDLE` on clear-by-read, when the byte is read while showing the transmit-empty code. It also makes that move on refill, when the empty flag drops. An arm event in the same cycle takes precedence over both clears. The edge detectors sample their inputs during reset as well, so the first cycle after reset sees no false edge.

The identification byte and the interrupt line are combinational functions of the inputs and the state. When a higher source clears, the next lower one shows in the same cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and after it, with no enabled source active and fifo_mode low, id_byte is 8'h01 and irq is 0; the state machine starts in TXE_IDLE.
- R2: Priority, highest first: line error (id code 3'b011), received data (3'b010), character timeout (3'b110), transmit empty (3'b001), modem change (3'b000). Received data wins over timeout when both are active.
- R3: Enable bit 0 gates received data and timeout, bit 1 gates transmit empty, bit 2 gates line error and bit 3 gates modem change. A disabled source never appears in id_byte and never raises irq.
- R4: Layout of id_byte: bit 0 is the pending flag, which is 0 when a source is pending. Bits [3:1] carry the id code. Bits [5:4] are always 00. Bits [7:6] are 11 when fifo_mode is high and 00 otherwise.
- R5: The timeout source is ignored when fifo_mode is low, so bit 3 of id_byte is then 0.
- R6: irq is 1 exactly when some enabled source is active, that is, exactly when bit 0 of id_byte is 0.
- R7: A rising edge of tx_empty sets the transmit-empty pending condition, visible from the cycle after the clock edge that sees the rise.
- R8: A clock edge with id_rd high while id_byte shows code 3'b001 with pending clears the transmit-empty condition. A read while another code is shown leaves it set.
- R9: With tx_empty high, a 0-to-1 change of enable bit 1 re-arms the transmit-empty condition.
- R10: A falling edge of tx_empty clears the transmit-empty condition.
- R11: When a higher source goes inactive, the next active lower source is shown in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ena | input | 4 | Interrupt enable mask (bit 0 rx/timeout, 1 tx empty, 2 line error, 3 modem) |
| fifo_mode | input | 1 | FIFO mode active |
| src_line_err | input | 1 | Receiver line error condition |
| src_rx_ready | input | 1 | Received data available condition |
| src_rx_timeout | input | 1 | Character timeout condition |
| tx_empty | input | 1 | Transmit holding register is empty |
| src_modem | input | 1 | Modem status change condition |
| id_rd | input | 1 | One-cycle read strobe of the identification byte |
| id_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt line, active high |

## Verification
The assertions assume that id_rd is a strobe sampled at clock edges. They also assume the source inputs are synchronous to clk, so that a previous-cycle value seen by an assertion matches the value the edge detectors hold. The clear-by-read property assumes tx_empty and enable bit 1 are steady across the read cycle. The bench changes every input only at the falling clock edge. It raises enables only after reset is released, and it moves tx_empty and enable bit 1 only in cycles without a read.

// File: rtl/uart_irq_ident_pkg.sv
package uart_irq_ident_pkg;
    localparam int ID_W   = 3;
    localparam int ENA_W  = 4;
    localparam int BYTE_W = 8;

    // enable bit positions
    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MS  = 3;

    // id codes, ordered by priority in the encoder
    localparam logic [ID_W-1:0] ID_LINE    = 3'b011;
    localparam logic [ID_W-1:0] ID_RXDATA  = 3'b010;
    localparam logic [ID_W-1:0] ID_TIMEOUT = 3'b110;
    localparam logic [ID_W-1:0] ID_TXEMPTY = 3'b001;
    localparam logic [ID_W-1:0] ID_MODEM   = 3'b000;

    typedef enum logic {
        TXE_IDLE = 1'b0,
        TXE_PEND = 1'b1
    } txe_state_t;
endpackage

// File: rtl/uart_txe_tracker.sv
module uart_txe_tracker
    import uart_irq_ident_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic tx_en,
    input  logic rd_clear,
    output logic pending
);
    txe_state_t state_q, state_d;
    logic empty_prev_q;
    logic en_prev_q;
    logic arm;

    // edge history follows the inputs even in reset: no false edge afterwards
    always_ff @(posedge clk) begin
        empty_prev_q <= tx_empty;
        en_prev_q    <= tx_en;
    end

    assign arm = (tx_empty && !empty_prev_q) || (tx_en && !en_prev_q && tx_empty);

    always_ff @(posedge clk) begin
        if (rst) state_q <= TXE_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_IDLE: if (arm) state_d = TXE_PEND;
            TXE_PEND: begin
                if (arm)                      state_d = TXE_PEND;
                else if (!tx_empty || rd_clear) state_d = TXE_IDLE;
            end
            default: state_d = TXE_IDLE;
        endcase
    end

    assign pending = (state_q == TXE_PEND);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_ident_pkg::*;
(
    input  logic [ENA_W-1:0] ena,
    input  logic             fifo_mode,
    input  logic             line_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             tx_pend,
    input  logic             modem,
    output logic [ID_W-1:0]  id_code,
    output logic             any,
    output logic             tx_sel
);
    logic act_ls, act_rx, act_to, act_tx, act_ms;

    assign act_ls = ena[EN_LS] && line_err;
    assign act_rx = ena[EN_RX] && rx_ready;
    assign act_to = ena[EN_RX] && rx_timeout && fifo_mode;
    assign act_tx = ena[EN_TX] && tx_pend;
    assign act_ms = ena[EN_MS] && modem;

    always_comb begin
        id_code = ID_MODEM;
        tx_sel  = 1'b0;
        any     = 1'b1;
        if      (act_ls) id_code = ID_LINE;
        else if (act_rx) id_code = ID_RXDATA;
        else if (act_to) id_code = ID_TIMEOUT;
        else if (act_tx) begin
            id_code = ID_TXEMPTY;
            tx_sel  = 1'b1;
        end
        else if (act_ms) id_code = ID_MODEM;
        else             any     = 1'b0;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_ident_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ENA_W-1:0]  ena,
    input  logic              fifo_mode,
    input  logic              src_line_err,
    input  logic              src_rx_ready,
    input  logic              src_rx_timeout,
    input  logic              tx_empty,
    input  logic              src_modem,
    input  logic              id_rd,
    output logic [BYTE_W-1:0] id_byte,
    output logic              irq
);
    logic            tx_pend;
    logic            tx_sel;
    logic            any;
    logic [ID_W-1:0] id_code;

    uart_txe_tracker u_txe (
        .clk      (clk),
        .rst      (rst),
        .tx_empty (tx_empty),
        .tx_en    (ena[EN_TX]),
        .rd_clear (id_rd && tx_sel),
        .pending  (tx_pend)
    );

    uart_irq_prio u_prio (
        .ena        (ena),
        .fifo_mode  (fifo_mode),
        .line_err   (src_line_err),
        .rx_ready   (src_rx_ready),
        .rx_timeout (src_rx_timeout),
        .tx_pend    (tx_pend),
        .modem      (src_modem),
        .id_code    (id_code),
        .any        (any),
        .tx_sel     (tx_sel)
    );

    always_comb begin
        id_byte = {{2{fifo_mode}}, 2'b00, id_code, !any};
        irq     = any;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ena,
    input logic       fifo_mode,
    input logic       src_line_err,
    input logic       src_rx_ready,
    input logic       src_rx_timeout,
    input logic       tx_empty,
    input logic       src_modem,
    input logic       id_rd,
    input logic [7:0] id_byte,
    input logic       irq
);
    AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
        (ena[2] && src_line_err) |-> (id_byte[3:1] == 3'b011 && !id_byte[0])); // R2
    AST_MODEM_ONLY_IF_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (!id_byte[0] && id_byte[3:1] == 3'b000) |-> (ena[3] && src_modem)); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (id_byte[5:4] == 2'b00) && (id_byte[7:6] == {2{fifo_mode}})); // R4
    AST_NO_TIMEOUT_NONFIFO: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |-> !id_byte[3]); // R5
    AST_IRQ_ON_RX: assert property (@(posedge clk) disable iff (rst)
        (ena[0] && src_rx_ready) |-> irq); // R6
    AST_IRQ_MATCHES_PEND: assert property (@(posedge clk) disable iff (rst)
        irq == !id_byte[0]); // R6
    AST_READ_CLEARS_TX: assert property (@(posedge clk) disable iff (rst)
        (id_rd && !id_byte[0] && id_byte[3:1] == 3'b001 && tx_empty && $past(tx_empty)
         && ena[1] && $past(ena[1])) |=> (id_byte[3:1] != 3'b001)); // R8
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
    .clk(clk), .rst(rst), .ena(ena), .fifo_mode(fifo_mode),
    .src_line_err(src_line_err), .src_rx_ready(src_rx_ready),
    .src_rx_timeout(src_rx_timeout), .tx_empty(tx_empty),
    .src_modem(src_modem), .id_rd(id_rd), .id_byte(id_byte), .irq(irq)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ena;
    logic       fifo_mode, src_line_err, src_rx_ready, src_rx_timeout;
    logic       tx_empty, src_modem, id_rd;
    logic [7:0] id_byte;
    logic       irq;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst(rst), .ena(ena), .fifo_mode(fifo_mode),
        .src_line_err(src_line_err), .src_rx_ready(src_rx_ready),
        .src_rx_timeout(src_rx_timeout), .tx_empty(tx_empty),
        .src_modem(src_modem), .id_rd(id_rd), .id_byte(id_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] exp_id, input logic exp_irq);
        #1;
        n_checks++;
        if (id_byte !== exp_id || irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: id_byte=%02h irq=%0b expected id_byte=%02h irq=%0b",
                     req, id_byte, irq, exp_id, exp_irq);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; ena = 4'h0; fifo_mode = 1'b0; src_line_err = 1'b0;
        src_rx_ready = 1'b0; src_rx_timeout = 1'b0; tx_empty = 1'b0;
        src_modem = 1'b0; id_rd = 1'b0;
        cyc(3);
        chk("R1 in reset", 8'h01, 1'b0);
        rst = 1'b0;
        cyc(1);
        chk("R1 after reset", 8'h01, 1'b0);
    endtask

    task automatic t_layout;
        fifo_mode = 1'b1;
        cyc(1);
        chk("R4 fifo bits idle", 8'hC1, 1'b0);
        fifo_mode = 1'b0;
        cyc(1);
        chk("R4 non-fifo idle", 8'h01, 1'b0);
    endtask

    task automatic t_gating;
        src_line_err = 1'b1; src_rx_ready = 1'b1; src_modem = 1'b1;
        cyc(1);
        chk("R3 all disabled", 8'h01, 1'b0);
        ena = 4'h8;
        cyc(1);
        chk("R3 modem only enabled", 8'h00, 1'b1);
        ena = 4'h9;
        cyc(1);
        chk("R3 rx enabled", 8'h04, 1'b1);
        ena = 4'h0; src_line_err = 1'b0; src_rx_ready = 1'b0; src_modem = 1'b0;
        cyc(1);
        chk("R6 irq drops", 8'h01, 1'b0);
    endtask

    task automatic t_priority;
        ena = 4'hF; src_modem = 1'b1;
        cyc(1);
        chk("R2 modem", 8'h00, 1'b1);
        tx_empty = 1'b1;
        cyc(1);
        chk("R7 tx empty armed", 8'h02, 1'b1);
        src_rx_ready = 1'b1;
        cyc(1);
        chk("R2 rx over tx", 8'h04, 1'b1);
        fifo_mode = 1'b1; src_rx_timeout = 1'b1;
        cyc(1);
        chk("R2 rx over timeout", 8'hC4, 1'b1);
        src_rx_ready = 1'b0;
        cyc(1);
        chk("R11 timeout shows", 8'hCC, 1'b1);
        src_line_err = 1'b1;
        cyc(1);
        chk("R2 line error highest", 8'hC6, 1'b1);
        src_line_err = 1'b0;
        cyc(1);
        chk("R11 back to timeout", 8'hCC, 1'b1);
        fifo_mode = 1'b0;
        cyc(1);
        chk("R5 timeout ignored non-fifo", 8'h02, 1'b1);
        src_rx_timeout = 1'b0;
        cyc(1);
    endtask

    task automatic t_read_clear;
        id_rd = 1'b1;
        cyc(1);
        id_rd = 1'b0;
        chk("R8 read clears tx", 8'h00, 1'b1);
        tx_empty = 1'b0;
        cyc(1);
        tx_empty = 1'b1;
        cyc(1);
        chk("R7 rearm on new empty", 8'h02, 1'b1);
        tx_empty = 1'b0;
        cyc(1);
        chk("R10 fill clears tx", 8'h00, 1'b1);
        tx_empty = 1'b1;
        cyc(1);
        src_rx_ready = 1'b1;
        cyc(1);
        chk("R2 rx shown before read", 8'h04, 1'b1);
        id_rd = 1'b1;
        cyc(1);
        id_rd = 1'b0; src_rx_ready = 1'b0;
        cyc(1);
        chk("R8 other read keeps tx", 8'h02, 1'b1);
    endtask

    task automatic t_rearm_enable;
        id_rd = 1'b1;
        cyc(1);
        id_rd = 1'b0;
        chk("R8 cleared again", 8'h00, 1'b1);
        ena = 4'hD;
        cyc(1);
        chk("R3 tx disabled", 8'h00, 1'b1);
        ena = 4'hF;
        cyc(1);
        chk("R9 enable rise rearms", 8'h02, 1'b1);
        src_modem = 1'b0;
        cyc(1);
        chk("R6 tx alone raises irq", 8'h02, 1'b1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: timed out expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_layout();
        t_gating();
        t_priority();
        t_read_clear();
        t_rearm_enable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule